// File: doc/BRIEF.md
# SPI Slave Register Access Decoder

This block is the serial front end of a register map. An external SPI master (mode 0, most significant bit first) opens each transfer by pulling chip select low and sending a command. The command comes in one of two lengths. A one-byte short command reaches a 6-bit register space. A two-byte long command reaches a 10-bit space, which holds the wider control registers and the packet buffers. After the command, every complete byte that follows is either written to the register file or read from it. The address steps forward by one for each byte, so a single transfer can stream a whole packet buffer in or out.

All SPI lines are brought into the system clock domain through synchronizer chains. SCK edges are found there, so the design has a single clock. On the core side the block drives a plain synchronous register-file port: an address, write data, a one-cycle write strobe, a one-cycle read strobe, and read data that the register file returns combinationally from the address in the cycle the read strobe is high. The port has no back-pressure. A strobe is always accepted in its own cycle. This is why SCK must stay high and low for at least 4 system clocks each, so that the strobe, the data load and the next SCK edge never overlap.

Top module: `spi_reg_bridge`

## Requirements
- R1: A first command byte with bit 7 clear is a short command. Bits 6:1 are the register address and bit 0 is set for a write. The resulting address is zero-extended to 10 bits.
- R2: A first command byte with bit 7 set starts a long command. Together with the second byte it forms a 16-bit word in which bits 14:5 are the address and bit 4 is set for a write. Bits 3:0 have no effect.
- R3: In a write transfer, each complete byte after the command produces exactly one reg_we pulse, with the byte on reg_wdata (first bit received is bit 7) and the target address on reg_addr.
- R4: Successive write bytes go to consecutive addresses. A short transfer wraps from 0x3F to 0x00 and a long transfer wraps from 0x3FF to 0x000.
- R5: A read command raises reg_re for the addressed register when its last command bit arrives. The returned byte appears on spi_miso most significant bit first during the next byte. Each bit is updated after an SCK falling edge and is valid at the following rising edge.
- R6: In a read transfer, the end of every data byte raises reg_re at the next address (same wrapping as R4), and that byte is shifted out during the following byte.
- R7: Raising chip select at any point ends the transfer. A byte that was not complete is never written, even when its last SCK rising edge coincides with the deselect, and the next transfer is decoded as a fresh command.
- R8: spi_miso_oe is high only while chip select is low (after synchronization). spi_miso is 0 while the command bytes of a read are being received.
- R9: reg_we and reg_re are never high in the same cycle, and each strobe lasts one cycle.
- R10: After reset no strobe is active, spi_miso_oe is low and reg_addr is 0.
- R11: The byte shifted out for a read is the value on reg_rdata in the cycle reg_re was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Serial data from master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_addr | output | 10 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register-file read data, valid while reg_re is high |

## Verification
Two events can land in the same synchronized cycle: the SCK rising edge that completes a data byte, and the chip-select release that ends the transfer. The bench provokes this by raising SCK and chip select together on the final bit of a write byte. Because both lines pass through synchronizer chains of equal depth, the two events reach the decoder together. The outcome is judged by the absence of any write strobe. A following read of the same register then shows its value unchanged, and a further transfer shows the decoder back at command start.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    PH_CMD0 = 2'd0,
    PH_CMD1 = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic cs_act
);
  localparam int LINES = 3;
  localparam logic [LINES-1:0] IDLE_LVL = 3'b100;

  logic [LINES-1:0] din;
  logic [LINES-1:0] sync;
  logic             sck_d;

  assign din = {cs_n, mosi, sck};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{IDLE_LVL[g]}};
        else        chain <= {chain[STAGES-2:0], din[g]};
      end
      assign sync[g] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sync[0];
  end

  assign sck_rise = sync[0] & ~sck_d;
  assign sck_fall = ~sync[0] & sck_d;
  assign mosi_s   = sync[1];
  assign cs_act   = ~sync[2];
endmodule

// File: rtl/spi_rd_cmd.sv
module spi_rd_cmd
  import spi_rd_pkg::*;
#(
  parameter int SHORT_AW = 6,
  parameter int LONG_AW  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_rise,
  input  logic               mosi_s,
  input  logic               cs_act,
  output logic [LONG_AW-1:0] reg_addr,
  output logic [BYTE_W-1:0]  reg_wdata,
  output logic               reg_we,
  output logic               reg_re
);
  localparam int CMD_W = 2 * BYTE_W;
  localparam int L_WR  = CMD_W - 2 - LONG_AW;
  localparam int S_MSB = BYTE_W - 2;
  localparam int S_WR  = S_MSB - SHORT_AW;

  logic [CNT_W-1:0]   bitcnt;
  logic [BYTE_W-2:0]  rx, hi;
  phase_t             phase;
  logic               is_short, is_write;
  logic [LONG_AW-1:0] ptr;

  logic [BYTE_W-1:0]  byte_in;
  logic               byte_done;
  logic [LONG_AW-1:0] s_addr, l_addr;
  logic               s_wr, l_wr;

  function automatic logic [LONG_AW-1:0] step(input logic [LONG_AW-1:0] a, input logic s);
    logic [LONG_AW-1:0] n;
    n = a + 1'b1;
    if (s) n = LONG_AW'(n[SHORT_AW-1:0]);
    return n;
  endfunction

  always_comb begin
    byte_in   = {rx, mosi_s};
    byte_done = (bitcnt == CNT_W'(BYTE_W - 1));
    s_addr    = LONG_AW'(byte_in[S_MSB -: SHORT_AW]);
    s_wr      = byte_in[S_WR];
    l_addr    = LONG_AW'({hi, byte_in} >> (L_WR + 1));
    l_wr      = byte_in[L_WR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      rx        <= '0;
      hi        <= '0;
      phase     <= PH_CMD0;
      is_short  <= 1'b0;
      is_write  <= 1'b0;
      ptr       <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (!cs_act) begin
        bitcnt <= '0;
        phase  <= PH_CMD0;
      end else if (sck_rise) begin
        rx     <= byte_in[BYTE_W-2:0];
        bitcnt <= byte_done ? '0 : bitcnt + 1'b1;
        if (byte_done) begin
          unique case (phase)
            PH_CMD0: begin
              if (!byte_in[BYTE_W-1]) begin
                phase    <= PH_DATA;
                is_short <= 1'b1;
                is_write <= s_wr;
                if (s_wr) ptr <= s_addr;
                else begin
                  reg_re   <= 1'b1;
                  reg_addr <= s_addr;
                  ptr      <= step(s_addr, 1'b1);
                end
              end else begin
                hi    <= byte_in[BYTE_W-2:0];
                phase <= PH_CMD1;
              end
            end
            PH_CMD1: begin
              phase    <= PH_DATA;
              is_short <= 1'b0;
              is_write <= l_wr;
              if (l_wr) ptr <= l_addr;
              else begin
                reg_re   <= 1'b1;
                reg_addr <= l_addr;
                ptr      <= step(l_addr, 1'b0);
              end
            end
            default: begin
              if (is_write) begin
                reg_we    <= 1'b1;
                reg_wdata <= byte_in;
              end else begin
                reg_re <= 1'b1;
              end
              reg_addr <= ptr;
              ptr      <= step(ptr, is_short);
            end
          endcase
        end
      end
    end
  end

  logic [LONG_AW-1:0] last_we;
  logic               have_we;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_we <= '0;
      have_we <= 1'b0;
    end else if (!cs_act) begin
      have_we <= 1'b0;
    end else if (reg_we) begin
      have_we <= 1'b1;
      last_we <= reg_addr;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_we && reg_re)); // R9
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we); // R9
  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) (reg_we || reg_re) |-> $past(cs_act)); // R7
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !cs_act |=> (phase == PH_CMD0 && bitcnt == '0)); // R7
  AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ((reg_we || reg_re) && is_short) |-> (reg_addr >> SHORT_AW) == '0); // R1
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (reg_we && have_we) |-> reg_addr == step(last_we, is_short)); // R4
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx
  import spi_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              miso,
  output logic              miso_oe
);
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      miso  <= 1'b0;
    end else if (!cs_act) begin
      shreg <= '0;
      miso  <= 1'b0;
    end else if (load) begin
      shreg <= load_data;
    end else if (sck_fall) begin
      miso  <= shreg[BYTE_W-1];
      shreg <= {shreg[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso_oe = cs_act;

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !cs_act |=> !miso); // R8
  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n) load |-> !sck_fall); // R5
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import spi_rd_pkg::*;
#(
  parameter int SHORT_AW    = 6,
  parameter int LONG_AW     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sck,
  input  logic               spi_mosi,
  input  logic               spi_cs_n,
  output logic               spi_miso,
  output logic               spi_miso_oe,
  output logic [LONG_AW-1:0] reg_addr,
  output logic [BYTE_W-1:0]  reg_wdata,
  output logic               reg_we,
  output logic               reg_re,
  input  logic [BYTE_W-1:0]  reg_rdata
);
  logic sck_rise, sck_fall, mosi_s, cs_act;

  spi_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s), .cs_act(cs_act)
  );

  spi_rd_cmd #(.SHORT_AW(SHORT_AW), .LONG_AW(LONG_AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .mosi_s(mosi_s), .cs_act(cs_act),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re)
  );

  spi_rd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall),
    .load(reg_re), .load_data(reg_rdata), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );
endmodule

// File: tb/test_spi_reg_bridge.sv
module test_spi_reg_bridge;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic       spi_miso, spi_miso_oe;
  logic [9:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_we, reg_re;
  logic [7:0] mem [1024];
  logic [3:0] cs_hist = 4'hF;
  int checks = 0, fails = 0;
  int q_kind[$], q_addr[$], q_data[$];

  spi_reg_bridge i_spi_reg_bridge (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  // behavioural register file: combinational read, clocked write
  assign reg_rdata = mem[reg_addr];
  initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;
  always @(posedge clk) cs_hist <= {cs_hist[2:0], cs_n};

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // every clock: strobes against predicted queue, output enable against chip select
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we || reg_re) begin
        check(!(reg_we && reg_re), "R9", "both strobes", 1, 0);
        if (q_kind.size() == 0) begin
          check(0, reg_we ? "R3/R7" : "R6/R7", "unexpected strobe addr", int'(reg_addr), -1);
        end else begin
          int k, a, d;
          k = q_kind.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
          check(k == (reg_we ? 1 : 0), k ? "R3" : "R5", "strobe kind", reg_we, k);
          check(int'(reg_addr) == a, k ? "R4" : "R6", "strobe addr", int'(reg_addr), a);
          if (k == 1) check(int'(reg_wdata) == d, "R3", "write data", int'(reg_wdata), d);
        end
      end
      if (cs_hist == {4{cs_hist[0]}})
        check(spi_miso_oe == !cs_hist[0], "R8", "miso_oe", spi_miso_oe, !cs_hist[0]);
    end
  end

  function automatic int nxt(input int a, input bit lng);
    return lng ? (a + 1) % 1024 : (a + 1) % 64;
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] tx, input int nbits, input bit abort_last, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      mosi = tx[7-i];
      wclk(HALF);
      rx[7-i] = spi_miso;
      if (abort_last && i == nbits - 1) begin
        sck = 1'b1;
        cs_n = 1'b1;
      end else begin
        sck = 1'b1;
      end
      wclk(HALF);
    end
  endtask

  task automatic do_xfer(input bit lng, input bit wr, input int addr, input int n, input int seed,
                         input int partial, input bit abort_same, input string req);
    logic [7:0] rx;
    logic [15:0] cw;
    int a;
    int expb[$];
    a = addr;
    if (wr) begin
      for (int k = 0; k < n; k++) begin
        q_kind.push_back(1); q_addr.push_back(a); q_data.push_back((seed + k * 29) & 255);
        a = nxt(a, lng);
      end
    end else begin
      q_kind.push_back(0); q_addr.push_back(a); q_data.push_back(0);
      for (int k = 0; k < n; k++) begin
        expb.push_back(int'(mem[a]));
        a = nxt(a, lng);
        q_kind.push_back(0); q_addr.push_back(a); q_data.push_back(0);
      end
    end
    cs_n = 1'b0;
    wclk(HALF);
    if (lng) begin
      cw = 16'h8000 | 16'((addr & 1023) << 5) | 16'(wr << 4) | 16'h000F; // R2 low nibble set
      send_byte(cw[15:8], 8, 1'b0, rx);
      if (!wr) check(rx == 0, "R8", "miso during command", rx, 0);
      send_byte(cw[7:0], 8, 1'b0, rx);
      if (!wr) check(rx == 0, "R8", "miso during command", rx, 0);
    end else begin
      send_byte({1'b0, 6'(addr), wr}, 8, 1'b0, rx); // R1 short form
      if (!wr) check(rx == 0, "R8", "miso during command", rx, 0);
    end
    for (int k = 0; k < n; k++) begin
      send_byte(wr ? 8'((seed + k * 29) & 255) : 8'h00, 8, 1'b0, rx);
      if (!wr) check(int'(rx) == expb[k], req, "miso byte (R11)", rx, expb[k]);
    end
    if (partial > 0) send_byte(8'hFF, partial, abort_same, rx);
    sck = 1'b0;
    wclk(HALF);
    cs_n = 1'b1;
    wclk(4 * HALF);
    check(q_kind.size() == 0, req, "strobes missing", q_kind.size(), 0);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wclk(150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] rx;
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    // R10 reset state
    check(!reg_we && !reg_re, "R10", "strobes after reset", {reg_we, reg_re}, 0);
    check(!spi_miso_oe, "R10", "oe after reset", spi_miso_oe, 0);
    check(reg_addr == 0, "R10", "addr after reset", reg_addr, 0);
    wclk(4);

    do_xfer(0, 1, 6'h12, 1, 8'hA5, 0, 0, "R3");  // R1 short single write
    do_xfer(0, 0, 6'h12, 1, 0, 0, 0, "R5");      // R5 short single read back
    do_xfer(1, 1, 10'h300, 3, 8'h3C, 0, 0, "R2"); // R2 long burst write, don't-care bits set
    do_xfer(1, 0, 10'h301, 4, 0, 0, 0, "R6");    // R6 long burst read
    do_xfer(0, 1, 6'h3E, 4, 8'h11, 0, 0, "R4");  // R4 short wrap 3F->00
    do_xfer(0, 0, 6'h3E, 4, 0, 0, 0, "R6");      // R6 short read wrap
    do_xfer(1, 0, 10'h3FE, 3, 0, 0, 0, "R6");    // R6 long read wrap 3FF->000
    do_xfer(1, 1, 10'h3FF, 2, 8'h77, 0, 0, "R4"); // R4 long write wrap
    do_xfer(1, 0, 10'h3FF, 2, 0, 0, 0, "R11");

    // R7: one full byte then a half byte; only the full byte is written
    do_xfer(0, 1, 6'h20, 1, 8'h5A, 4, 0, "R7");
    do_xfer(0, 0, 6'h20, 2, 0, 0, 0, "R7");
    // R7: deselect on the same edge that would complete the byte
    do_xfer(0, 1, 6'h21, 0, 0, 8, 1, "R7");
    do_xfer(0, 0, 6'h21, 1, 0, 0, 0, "R7");
    // R7: abort between the two long command bytes, then a fresh short command
    cs_n = 1'b0;
    wclk(HALF);
    send_byte(8'hC0, 8, 1'b0, rx);
    sck = 1'b0;
    wclk(HALF);
    cs_n = 1'b1;
    wclk(4 * HALF);
    check(q_kind.size() == 0, "R7", "strobe after aborted command", q_kind.size(), 0);
    do_xfer(0, 0, 6'h05, 1, 0, 0, 0, "R7");

    finish_up();
  end
endmodule